// File: doc/BRIEF.md
# Two-Level Priority Command Arbiter with Aging

This block picks which pending memory command goes next. A small queue of read and write requests sits outside the block. For each slot the block sees a valid bit and the quality-of-service value that arrived with the request on its AXI address channel. In each cycle the block returns a one-hot grant for at most one slot and a grant-valid flag. The grant is combinational from the current inputs and the registered arbitration state.

A QoS value above a configurable threshold makes the request high priority. Any other value makes it normal priority. High requests beat normal ones. Within a level, a separate round-robin pointer for that level rotates the grants. Each slot also has a saturating wait counter. When a counter reaches a configurable age limit, that slot overrides both levels. Because of this, a request that stays valid cannot be passed over forever.

Top module: `prio_age_arbiter`

## Requirements
- R1: A slot is high priority when its QoS value is strictly greater than QOS_THRESH. Otherwise it is normal priority.
- R2: When no valid slot is aged, and at least one valid slot is high priority, the grant goes to a high-priority slot.
- R3: A round-robin grant at a level goes to the first valid slot of that level, scanning upward from that level's pointer and wrapping from slot N-1 to slot 0.
- R4: After a round-robin grant, the pointer of the granted level becomes the granted index plus one, modulo N. The other level's pointer holds. An age-override grant leaves both pointers unchanged. Both pointers are 0 after reset.
- R5: `grant` has at most one bit set. That bit is always a valid slot. `grant_valid` is high exactly when a bit of `grant` is set.
- R6: With no valid slot, `grant_valid` is low, `grant` is zero, and both pointers hold their values.
- R7: A slot's wait counter increments, saturating at 2^AGE_W-1, in each cycle that the slot is valid and not granted. The counter clears when the slot is granted or not valid. Counters are 0 after reset.
- R8: A valid slot whose counter is at least AGE_LIMIT is aged, and an aged slot wins over every non-aged slot. Among aged slots, the largest counter wins, and a tie goes to the lowest index.
- R9: A normal slot that is held valid while all other slots are high priority and held valid is granted after exactly AGE_LIMIT cycles of waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N | One valid bit per queue slot |
| req_qos | input | N*QOS_W | QoS value per slot; slot i occupies bits [i*QOS_W +: QOS_W] |
| grant | output | N | One-hot grant; zero when nothing is granted |
| grant_valid | output | 1 | High when a slot is granted this cycle |

## Verification
The age override and the round-robin pointer can fall in the same cycle. In that cycle an aged normal slot takes the grant while high-priority slots are also pending. The design must then leave both pointers alone, so the next non-aged grant still starts from where the rotation stood. This case is provoked in two ways: by long-held mixed patterns in the sweep, and by a directed starvation run. In that run, three high slots rotate while one normal slot waits. The grant is compared in every cycle against an arithmetic model that keeps its own pointers and counters. The starvation run also measures the wait length against AGE_LIMIT.

// File: rtl/prio_age_arbiter.sv
module prio_age_arbiter #(
  parameter int N          = 4,
  parameter int QOS_W      = 4,
  parameter int QOS_THRESH = 7,
  parameter int AGE_W      = 4,
  parameter int AGE_LIMIT  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       req_valid,
  input  logic [N*QOS_W-1:0] req_qos,
  output logic [N-1:0]       grant,
  output logic               grant_valid
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(AGE_LIMIT);

  logic [AGE_W-1:0] age [N];
  logic [PW-1:0]    hi_ptr, lo_ptr;
  logic [N-1:0]     hi_req, lo_req, aged;
  logic [N-1:0]     age_gnt, hi_gnt, lo_gnt;
  logic [PW-1:0]    gnt_idx;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign hi_req[i] = req_valid[i] && (req_qos[i*QOS_W +: QOS_W] > QOS_W'(QOS_THRESH));
    assign lo_req[i] = req_valid[i] && !hi_req[i];
    assign aged[i]   = req_valid[i] && (age[i] >= AGE_LIM);

    always_ff @(posedge clk) begin
      if (!rst_n)                        age[i] <= '0;
      else if (!req_valid[i] || grant[i]) age[i] <= '0;
      else if (age[i] != AGE_MAX)        age[i] <= age[i] + 1'b1;
    end

    // R7
    age_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && !grant[i] && age[i] != AGE_MAX) |=> age[i] == $past(age[i]) + 1'b1);
  end

  function automatic logic [N-1:0] rr_pick(input logic [N-1:0] m, input logic [PW-1:0] p);
    logic [N-1:0] g;
    logic hit;
    int idx;
    g = '0;
    hit = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(p) + k) % N;
      if (!hit && m[idx]) begin
        g[idx] = 1'b1;
        hit = 1'b1;
      end
    end
    return g;
  endfunction

  always_comb begin
    logic [AGE_W-1:0] best;
    logic hit;
    age_gnt = '0;
    best = '0;
    hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (aged[i] && (!hit || age[i] > best)) begin
        age_gnt = '0;
        age_gnt[i] = 1'b1;
        best = age[i];
        hit = 1'b1;
      end
    end
  end

  assign hi_gnt = rr_pick(hi_req, hi_ptr);
  assign lo_gnt = rr_pick(lo_req, lo_ptr);

  assign grant = (|aged)   ? age_gnt :
                 (|hi_req) ? hi_gnt  : lo_gnt;
  assign grant_valid = |grant;

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < N; i++)
      if (grant[i]) gnt_idx = PW'(i);
  end

  wire [PW-1:0] nxt_ptr = (int'(gnt_idx) == N-1) ? '0 : gnt_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_ptr <= '0;
      lo_ptr <= '0;
    end else if (grant_valid && !(|aged)) begin
      if (|hi_req) hi_ptr <= nxt_ptr;
      else         lo_ptr <= nxt_ptr;
    end
  end

  // R5
  onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  // R5
  gnt_valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n) (grant & ~req_valid) == '0);
  // R6
  idle_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_valid) |=> (hi_ptr == $past(hi_ptr)) && (lo_ptr == $past(lo_ptr)));
  // R8
  aged_wins_chk: assert property (@(posedge clk) disable iff (!rst_n) (|aged) |-> (|(grant & aged)));
  // R2
  high_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|aged) && (|hi_req)) |-> (|(grant & hi_req)));
endmodule

// File: tb/prio_age_arbiter_bench.sv
module prio_age_arbiter_bench;
  localparam int N = 4, QW = 4, TH = 7, AW = 4, LIM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] v = '0;
  logic [N*QW-1:0] q = '0;
  logic [N-1:0] grant;
  logic grant_valid;

  int n_tests = 0, n_fail = 0;
  int m_age [N];
  int m_hp = 0, m_lp = 0;
  int last_idx;

  always #5 clk = ~clk;

  prio_age_arbiter #(.N(N), .QOS_W(QW), .QOS_THRESH(TH), .AGE_W(AW), .AGE_LIMIT(LIM)) u_prio_age_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .req_qos(q),
    .grant(grant), .grant_valid(grant_valid));

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] vi, input logic [N*QW-1:0] qi);
    int best, h_any;
    logic [N-1:0] exp_g;
    string tag;
    @(negedge clk);
    v = vi; q = qi;
    #1;
    best = -1; h_any = 0; tag = "R6";
    for (int i = 0; i < N; i++)
      if (vi[i] && m_age[i] >= LIM && (best < 0 || m_age[i] > m_age[best])) best = i;
    if (best >= 0) tag = "R8/R7";
    else begin
      for (int i = 0; i < N; i++) if (vi[i] && int'(qi[i*QW +: QW]) > TH) h_any = 1;
      for (int k = 0; k < N && best < 0; k++) begin
        int i;
        i = ((h_any ? m_hp : m_lp) + k) % N;
        if (vi[i] && ((int'(qi[i*QW +: QW]) > TH) == (h_any == 1))) best = i;
      end
      if (best >= 0) begin
        tag = h_any ? "R2/R3/R4" : "R3/R4";
        if (h_any) m_hp = (best + 1) % N; else m_lp = (best + 1) % N;
      end
    end
    exp_g = (best >= 0) ? N'(1) << best : '0;
    check(tag, grant, exp_g);
    check("R5", {{(N-1){1'b0}}, grant_valid}, {{(N-1){1'b0}}, best >= 0});
    for (int i = 0; i < N; i++)
      m_age[i] = (vi[i] && i != best) ? ((m_age[i] + 1 > 15) ? 15 : m_age[i] + 1) : 0;
    last_idx = best;
  endtask

  function automatic logic [N*QW-1:0] mkq(input logic [N-1:0] hi, input int salt);
    logic [N*QW-1:0] r;
    for (int i = 0; i < N; i++)
      r[i*QW +: QW] = hi[i] ? QW'(TH + 1 + ((salt + i) % (15 - TH))) : QW'((salt * 3 + i) % (TH + 1));
    return r;
  endfunction

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int wait_cnt;
    for (int i = 0; i < N; i++) m_age[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R6 reset", grant, '0);
    // exhaustive sweep of valid x priority masks, held for several cycles
    for (int vm = 0; vm < 16; vm++)
      for (int hm = 0; hm < 16; hm++)
        for (int r = 0; r < 3; r++)
          step(N'(vm), mkq(N'(hm), vm + hm + r));
    // long holds to drive aging
    for (int vm = 1; vm < 16; vm++)
      for (int r = 0; r < 12; r++)
        step(N'(vm), mkq(N'(vm ^ 4'b0101), r));
    // R1 threshold boundary
    step('0, '0);
    step(4'b0011, {8'h00, 4'(TH + 1), 4'(TH)});
    check("R1 qos above thresh", grant, 4'b0010);
    step('0, '0);
    step(4'b0011, {8'h00, 4'(TH), 4'(TH + 1)});
    check("R1 qos at thresh", grant, 4'b0001);
    // R9 starvation bound
    step('0, '0);
    wait_cnt = 0;
    last_idx = -1;
    while (last_idx != 0 && wait_cnt < 40) begin
      step(4'b1111, {4'hF, 4'hC, 4'h8, 4'h0});
      if (last_idx != 0) wait_cnt++;
    end
    n_tests++;
    if (wait_cnt != LIM) begin
      n_fail++;
      $display("FAIL R9: actual wait %0d expected %0d", wait_cnt, LIM);
    end
    // random traffic
    for (int r = 0; r < 3000; r++)
      step(N'($urandom), (N*QW)'($urandom));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule